// File: doc/BRIEF.md
# Instruction Fetch and Cache-Miss Stall Sequencer

This block is the cycle-level control sequencer of a single-issue, in-order core. While the core is running, it issues one instruction fetch per cycle. The instruction cache answers in the same cycle with a hit or a miss. On a hit the fetched instruction executes at once. An instruction that references memory also drives a data-cache access in that same cycle, and the data cache answers it with its own hit or miss.

A miss on either cache parks the sequencer in a wait state until a shared completion pulse arrives. After an instruction-cache miss, the fetched word is kept. The sequencer then passes through a held state in which that word executes without a second fetch. A data-cache miss stalls after the instruction has already retired.

Cycles spent waiting on each cache are accumulated into saturating counters. The length of each wait is measured against a free-running cycle count. An inactive thread parks the sequencer in Idle. A switch-out request freezes it in a terminal state that silently absorbs late completions. A completion pulse that arrives when no miss is pending, outside that terminal state, raises a sticky error. Decode, execution and cache internals sit outside the block and appear only as stimulus inputs.

Top module: `fetch_stall_seq`

## Requirements
- R1: After reset, state_o is Idle (code 0), pc_o equals RESET_PC, npc_o equals RESET_PC+4, all counters are zero, err_o is 0, and exec_en_o and fetch_valid_o are 0 while thread_active_i is low.
- R2: In Running (code 1) with thread_active_i high and switch_out_i low, fetch_valid_o is 1 and fetch_addr_o equals pc_o with bits [1:0] forced to zero; in every other state fetch_valid_o is 0.
- R3: A fetch that hits (ic_hit_i high) executes in the same cycle (exec_en_o high). Without fault_i, pc_o takes the old npc_o and npc_o grows by 4 at the next edge. With fault_i, both stay unchanged. inst_cnt_o increments once per executed instruction.
- R4: A fetch that misses keeps exec_en_o low in that cycle and moves the state to the I-cache wait (code 2), with pc_o unchanged.
- R5: In the I-cache wait, state holds until done_i. A done_i moves it to the I-cache held state (code 3) and adds to ic_stall_o the number of cycles from the miss cycle to the done cycle.
- R6: In the held state, fetch_valid_o is 0 and exec_en_o is 1 regardless of ic_hit_i. The next state is Running, or the D-cache wait if the held instruction misses in the data cache.
- R7: An executed instruction with mem_ref_i high raises dc_req_o and increments mem_cnt_o. A dc_hit_i low moves the state to the D-cache wait (code 4). A done_i there returns to Running and adds the elapsed cycles to dc_stall_o.
- R8: ic_stall_o and dc_stall_o saturate at all ones and never wrap.
- R9: switch_out_i moves the state to Switched-out (code 5) from any state, and it stays there until reset. In that state exec_en_o and fetch_valid_o are 0, and done_i changes no state, counter or err_o.
- R10: done_i arriving in Idle, Running or the held state sets err_o, which stays set until reset, and leaves the state unchanged.
- R11: With thread_active_i low (and not switched out), nothing executes or fetches, and the next state is Idle. In Idle with thread_active_i high, the next state is Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_active_i | input | 1 | Thread is active |
| switch_out_i | input | 1 | Request to switch the sequencer out |
| ic_hit_i | input | 1 | Instruction cache hit for this cycle's fetch |
| dc_hit_i | input | 1 | Data cache hit for this cycle's access |
| mem_ref_i | input | 1 | Executing instruction references memory |
| fault_i | input | 1 | Executing instruction faulted |
| done_i | input | 1 | Shared miss-completion pulse |
| fetch_valid_o | output | 1 | Fetch issued this cycle |
| fetch_addr_o | output | PC_W | Word-aligned fetch address |
| exec_en_o | output | 1 | Instruction executes this cycle |
| dc_req_o | output | 1 | Data cache access this cycle |
| pc_o | output | PC_W | Program counter |
| npc_o | output | PC_W | Next program counter |
| state_o | output | 3 | Sequencer state code |
| err_o | output | 1 | Sticky stray-completion error |
| inst_cnt_o | output | CNT_W | Executed instruction count |
| mem_cnt_o | output | CNT_W | Memory reference count |
| ic_stall_o | output | STALL_W | Instruction-cache stall cycles |
| dc_stall_o | output | STALL_W | Data-cache stall cycles |

## Verification
The hardest conditions to reach from the ports are counter saturation and a late completion after switch-out. The bench builds the block with an 8-bit stall counter and holds one I-cache miss open for 300 cycles before pulsing done_i. The bench then opens a second short miss to show that the counter stays pinned. For the switch-out case, it first parks the sequencer in the I-cache wait, then asserts switch_out_i, and only afterwards pulses done_i. It then shows that state, error flag and stall counter are untouched. A separate run drops thread_active_i during a D-cache wait, so that the following completion lands in Idle and must raise the error.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_IC_WAIT = 3'd2,
    ST_IC_HELD = 3'd3,
    ST_DC_WAIT = 3'd4,
    ST_OUT     = 3'd5
  } seq_state_e;

  localparam int NUM_STALL_SRC = 2;
  localparam int SRC_IC = 0;
  localparam int SRC_DC = 1;
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       sw_out_i,
  input  logic       ic_hit_i,
  input  logic       dc_hit_i,
  input  logic       mem_ref_i,
  input  logic       done_i,
  output seq_state_e state_o,
  output logic       fetch_v_o,
  output logic       exec_o,
  output logic       dc_req_o,
  output logic [NUM_STALL_SRC-1:0] stall_start_o,
  output logic [NUM_STALL_SRC-1:0] stall_end_o,
  output logic       err_o
);
  seq_state_e st_q, st_d;
  logic err_q;
  logic live;
  logic ic_miss, dc_miss;

  assign live      = active_i & ~sw_out_i & (st_q != ST_OUT);
  assign fetch_v_o = live & (st_q == ST_RUN);
  assign exec_o    = live & (((st_q == ST_RUN) & ic_hit_i) | (st_q == ST_IC_HELD));
  assign dc_req_o  = exec_o & mem_ref_i;
  assign ic_miss   = fetch_v_o & ~ic_hit_i;
  assign dc_miss   = dc_req_o & ~dc_hit_i;

  assign stall_start_o[SRC_IC] = ic_miss;
  assign stall_start_o[SRC_DC] = dc_miss;
  assign stall_end_o[SRC_IC]   = live & done_i & (st_q == ST_IC_WAIT);
  assign stall_end_o[SRC_DC]   = live & done_i & (st_q == ST_DC_WAIT);

  always_comb begin
    st_d = st_q;
    if (sw_out_i || st_q == ST_OUT) begin
      st_d = ST_OUT;
    end else if (!active_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    st_d = ST_RUN;
        ST_RUN:     st_d = ic_miss ? ST_IC_WAIT : (dc_miss ? ST_DC_WAIT : ST_RUN);
        ST_IC_WAIT: st_d = done_i ? ST_IC_HELD : ST_IC_WAIT;
        ST_IC_HELD: st_d = dc_miss ? ST_DC_WAIT : ST_RUN;
        ST_DC_WAIT: st_d = done_i ? ST_RUN : ST_DC_WAIT;
        default:    st_d = ST_OUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      // stray completion: no miss outstanding and not switched out
      if (done_i && !sw_out_i &&
          (st_q == ST_IDLE || st_q == ST_RUN || st_q == ST_IC_HELD))
        err_q <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign err_o   = err_q;
endmodule

// File: rtl/fss_pc.sv
module fss_pc #(
  parameter int          PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic            fault_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic [PC_W-1:0] fetch_addr_o
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [PC_W-1:0] pc_q, npc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      npc_q <= RESET_PC + INSN_BYTES;
    end else if (exec_i && !fault_i) begin
      pc_q  <= npc_q;
      npc_q <= npc_q + INSN_BYTES;
    end
  end

  assign pc_o         = pc_q;
  assign npc_o        = npc_q;
  assign fetch_addr_o = {pc_q[PC_W-1:2], 2'b00};
endmodule

// File: rtl/fss_cnt.sv
module fss_cnt #(
  parameter int CNT_W = 32,
  parameter int CYC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic             mem_i,
  output logic [CNT_W-1:0] inst_cnt_o,
  output logic [CNT_W-1:0] mem_cnt_o,
  output logic [CYC_W-1:0] cycle_o
);
  logic [CNT_W-1:0] inst_q, mem_q;
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inst_q <= '0;
      mem_q  <= '0;
      cyc_q  <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (exec_i) inst_q <= inst_q + 1'b1;
      if (mem_i)  mem_q  <= mem_q + 1'b1;
    end
  end

  assign inst_cnt_o = inst_q;
  assign mem_cnt_o  = mem_q;
  assign cycle_o    = cyc_q;
endmodule

// File: rtl/fss_stall_acc.sv
module fss_stall_acc #(
  parameter int STALL_W = 32,
  parameter int CYC_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               end_i,
  input  logic [CYC_W-1:0]   now_i,
  output logic [STALL_W-1:0] total_o
);
  localparam int SUM_W = ((CYC_W > STALL_W) ? CYC_W : STALL_W) + 1;
  localparam logic [SUM_W-1:0] SAT_V = SUM_W'({STALL_W{1'b1}});

  logic [CYC_W-1:0]   start_q;
  logic [STALL_W-1:0] tot_q;
  logic [CYC_W-1:0]   span;
  logic [SUM_W-1:0]   sum;

  assign span = now_i - start_q;
  assign sum  = SUM_W'(tot_q) + SUM_W'(span);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      tot_q   <= '0;
    end else begin
      if (start_i) start_q <= now_i;
      if (end_i)   tot_q   <= (sum > SAT_V) ? {STALL_W{1'b1}} : sum[STALL_W-1:0];
    end
  end

  assign total_o = tot_q;
endmodule

// File: rtl/fetch_stall_seq.sv
module fetch_stall_seq
  import fss_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              CNT_W    = 32,
  parameter int              STALL_W  = 32,
  parameter int              CYC_W    = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               thread_active_i,
  input  logic               switch_out_i,
  input  logic               ic_hit_i,
  input  logic               dc_hit_i,
  input  logic               mem_ref_i,
  input  logic               fault_i,
  input  logic               done_i,
  output logic               fetch_valid_o,
  output logic [PC_W-1:0]    fetch_addr_o,
  output logic               exec_en_o,
  output logic               dc_req_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    npc_o,
  output logic [2:0]         state_o,
  output logic               err_o,
  output logic [CNT_W-1:0]   inst_cnt_o,
  output logic [CNT_W-1:0]   mem_cnt_o,
  output logic [STALL_W-1:0] ic_stall_o,
  output logic [STALL_W-1:0] dc_stall_o
);
  seq_state_e st;
  logic [NUM_STALL_SRC-1:0] stall_start, stall_end;
  logic [NUM_STALL_SRC-1:0][STALL_W-1:0] stall_tot;
  logic [CYC_W-1:0] now;

  fss_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (thread_active_i),
    .sw_out_i     (switch_out_i),
    .ic_hit_i     (ic_hit_i),
    .dc_hit_i     (dc_hit_i),
    .mem_ref_i    (mem_ref_i),
    .done_i       (done_i),
    .state_o      (st),
    .fetch_v_o    (fetch_valid_o),
    .exec_o       (exec_en_o),
    .dc_req_o     (dc_req_o),
    .stall_start_o(stall_start),
    .stall_end_o  (stall_end),
    .err_o        (err_o)
  );

  fss_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_i      (exec_en_o),
    .fault_i     (fault_i),
    .pc_o        (pc_o),
    .npc_o       (npc_o),
    .fetch_addr_o(fetch_addr_o)
  );

  fss_cnt #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exec_i    (exec_en_o),
    .mem_i     (dc_req_o),
    .inst_cnt_o(inst_cnt_o),
    .mem_cnt_o (mem_cnt_o),
    .cycle_o   (now)
  );

  for (genvar g = 0; g < NUM_STALL_SRC; g++) begin : g_stall
    fss_stall_acc #(.STALL_W(STALL_W), .CYC_W(CYC_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(stall_start[g]),
      .end_i  (stall_end[g]),
      .now_i  (now),
      .total_o(stall_tot[g])
    );
  end

  assign state_o    = st;
  assign ic_stall_o = stall_tot[SRC_IC];
  assign dc_stall_o = stall_tot[SRC_DC];
endmodule

// File: rtl/fetch_stall_seq_chk.sv
module fetch_stall_seq_chk
  import fss_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int STALL_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               thread_active_i,
  input logic               switch_out_i,
  input logic               ic_hit_i,
  input logic               fault_i,
  input logic               fetch_valid_o,
  input logic [PC_W-1:0]    fetch_addr_o,
  input logic               exec_en_o,
  input logic [PC_W-1:0]    pc_o,
  input logic [PC_W-1:0]    npc_o,
  input logic [2:0]         state_o,
  input logic               err_o,
  input logic [STALL_W-1:0] ic_stall_o,
  input logic [STALL_W-1:0] dc_stall_o
);
  // R2
  fetch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> (fetch_addr_o == {pc_o[PC_W-1:2], 2'b00}));

  // R3
  pc_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_o && !fault_i) |=> (pc_o == $past(npc_o)));

  // R4
  ic_miss_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && thread_active_i && !switch_out_i && !ic_hit_i)
      |=> (state_o == ST_IC_WAIT));

  // R6
  held_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IC_HELD && thread_active_i && !switch_out_i)
      |-> (exec_en_o && !fetch_valid_o));

  // R8
  ic_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (ic_stall_o >= $past(ic_stall_o)));

  // R8
  dc_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (dc_stall_o >= $past(dc_stall_o)));

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_OUT) |=> (state_o == ST_OUT));

  // R9
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_OUT) |-> (!exec_en_o && !fetch_valid_o));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind fetch_stall_seq fetch_stall_seq_chk #(.PC_W(PC_W), .STALL_W(STALL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .thread_active_i(thread_active_i),
  .switch_out_i   (switch_out_i),
  .ic_hit_i       (ic_hit_i),
  .fault_i        (fault_i),
  .fetch_valid_o  (fetch_valid_o),
  .fetch_addr_o   (fetch_addr_o),
  .exec_en_o      (exec_en_o),
  .pc_o           (pc_o),
  .npc_o          (npc_o),
  .state_o        (state_o),
  .err_o          (err_o),
  .ic_stall_o     (ic_stall_o),
  .dc_stall_o     (dc_stall_o)
);

// File: tb/sim_fetch_stall_seq.sv
`timescale 1ns/1ps
module sim_fetch_stall_seq;
  localparam logic [31:0] PC_BASE = 32'h0000_0102;
  localparam int SW = 8;
  localparam int NV = 12;
  // {act,sw,ih,dh,mr,ft,dn}, exp exec, exp fetch, exp state, exp pc offset
  localparam logic [19:0] VEC [NV] = '{
    {7'b1000000, 1'b0, 1'b0, 3'd1, 8'd0},
    {7'b1010000, 1'b1, 1'b1, 3'd1, 8'd4},
    {7'b1000000, 1'b0, 1'b1, 3'd2, 8'd4},
    {7'b1000000, 1'b0, 1'b0, 3'd2, 8'd4},
    {7'b1000001, 1'b0, 1'b0, 3'd3, 8'd4},
    {7'b1000000, 1'b1, 1'b0, 3'd1, 8'd8},
    {7'b1010100, 1'b1, 1'b1, 3'd4, 8'd12},
    {7'b1000001, 1'b0, 1'b0, 3'd1, 8'd12},
    {7'b1011100, 1'b1, 1'b1, 3'd1, 8'd16},
    {7'b1010010, 1'b1, 1'b1, 3'd1, 8'd16},
    {7'b0010000, 1'b0, 1'b0, 3'd0, 8'd16},
    {7'b1000000, 1'b0, 1'b0, 3'd1, 8'd16}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic act = 1'b0, sw = 1'b0, ih = 1'b0, dh = 1'b0, mr = 1'b0, ft = 1'b0, dn = 1'b0;
  logic fetch_valid, exec_en, dc_req, err;
  logic [31:0] fetch_addr, pc, npc, inst_cnt, mem_cnt;
  logic [2:0] state;
  logic [SW-1:0] ic_stall, dc_stall;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fetch_stall_seq #(.STALL_W(SW), .RESET_PC(PC_BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .thread_active_i(act), .switch_out_i(sw),
    .ic_hit_i(ih), .dc_hit_i(dh), .mem_ref_i(mr), .fault_i(ft), .done_i(dn),
    .fetch_valid_o(fetch_valid), .fetch_addr_o(fetch_addr), .exec_en_o(exec_en),
    .dc_req_o(dc_req), .pc_o(pc), .npc_o(npc), .state_o(state), .err_o(err),
    .inst_cnt_o(inst_cnt), .mem_cnt_o(mem_cnt), .ic_stall_o(ic_stall), .dc_stall_o(dc_stall)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // drive at negedge, settle, comb outputs valid until posedge
  task automatic drive(input logic [6:0] s);
    @(negedge clk);
    {act, sw, ih, dh, mr, ft, dn} = s;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    {act, sw, ih, dh, mr, ft, dn} = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", 32'(state), 32'd0);
    chk("R1 pc", pc, PC_BASE);
    chk("R1 npc", npc, PC_BASE + 32'd4);
    chk("R1 inst_cnt", inst_cnt, 32'd0);
    chk("R1 ic_stall", 32'(ic_stall), 32'd0);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 fetch_valid", 32'(fetch_valid), 32'd0);
    chk("R1 exec_en", 32'(exec_en), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:13]);
      chk($sformatf("R3/R6 exec v%0d", i), 32'(exec_en), 32'(VEC[i][12]));
      chk($sformatf("R2 fetch v%0d", i), 32'(fetch_valid), 32'(VEC[i][11]));
      if (VEC[i][11]) chk($sformatf("R2 addr v%0d", i), fetch_addr, pc & ~32'd3);
      tick();
      chk($sformatf("R4/R5 state v%0d", i), 32'(state), 32'(VEC[i][10:8]));
      chk($sformatf("R3 pc v%0d", i), pc, PC_BASE + 32'(VEC[i][7:0]));
    end
    chk("R3 inst_cnt", inst_cnt, 32'd5);
    chk("R7 mem_cnt", mem_cnt, 32'd2);
    chk("R5 ic_stall", 32'(ic_stall), 32'd2);
    chk("R7 dc_stall", 32'(dc_stall), 32'd1);
    chk("R10 no err yet", 32'(err), 32'd0);

    // R10: completion while running
    drive(7'b1010001);
    tick();
    chk("R10 err set", 32'(err), 32'd1);
    chk("R10 state kept", 32'(state), 32'd1);
    drive(7'b1010000);
    tick();
    chk("R10 err sticky", 32'(err), 32'd1);

    // R8: long I-cache stall saturates 8-bit counter
    do_reset();
    drive(7'b1000000); tick();
    drive(7'b1000000); tick();
    chk("R4 enter wait", 32'(state), 32'd2);
    for (int k = 0; k < 299; k++) begin
      drive(7'b1000000); tick();
    end
    chk("R5 still waiting", 32'(state), 32'd2);
    drive(7'b1000001); tick();
    chk("R8 ic_stall sat", 32'(ic_stall), 32'd255);
    drive(7'b1000000); tick();
    drive(7'b1000000); tick();
    drive(7'b1000000); tick();
    drive(7'b1000001); tick();
    chk("R8 ic_stall stays sat", 32'(ic_stall), 32'd255);

    // R9: switch-out during I-cache wait, late completion swallowed
    do_reset();
    drive(7'b1000000); tick();
    drive(7'b1000000); tick();
    chk("R4 wait before switch", 32'(state), 32'd2);
    drive(7'b1100000); tick();
    chk("R9 switched out", 32'(state), 32'd5);
    drive(7'b1010001);
    chk("R9 no exec", 32'(exec_en), 32'd0);
    chk("R9 no fetch", 32'(fetch_valid), 32'd0);
    tick();
    chk("R9 state after done", 32'(state), 32'd5);
    chk("R9 err untouched", 32'(err), 32'd0);
    chk("R9 ic_stall untouched", 32'(ic_stall), 32'd0);
    chk("R9 pc untouched", pc, PC_BASE);

    // R11: deactivation during D-cache wait, then stray completion in Idle
    do_reset();
    drive(7'b1000000); tick();
    drive(7'b1010100);
    chk("R7 dc_req", 32'(dc_req), 32'd1);
    tick();
    chk("R7 dc wait", 32'(state), 32'd4);
    drive(7'b0000000);
    chk("R11 no fetch inactive", 32'(fetch_valid), 32'd0);
    tick();
    chk("R11 forced idle", 32'(state), 32'd0);
    drive(7'b0000001); tick();
    chk("R10 err in idle", 32'(err), 32'd1);
    chk("R11 stays idle", 32'(state), 32'd0);
    chk("R7 dc_stall not added", 32'(dc_stall), 32'd0);
    drive(7'b1000000); tick();
    chk("R11 reactivate", 32'(state), 32'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule